// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block turns a serial bit stream into a wide parallel word. Each rising edge of the clock moves the stream one stage further along a chain of holding stages. A bank of holding latches sits behind the chain, one latch per stage. The latches copy the chain while the latch control is high and keep their value while it is low. An output-enable gate sits between the latches and the parallel pins.

The last stage of the chain also drives a serial cascade output. Feeding that output into the serial input of a second instance extends the chain across devices. A build-time parameter picks how the stages map onto the output pins, either forward or reversed. The two settings give two board layouts that shift in opposite directions around the pins.

Top module: `serial_latch_driver`

## Requirements
- R1: While rst_ni is low, all shift stages and all latches clear to zero, so out_o is all zeros and data_o is 0.
- R2: On each rising edge of clk_i the chain advances one stage: stage 1 takes data_i and stage k+1 takes the old stage k.
- R3: On an edge where le_i is high, the latches load the chain contents that result from that same edge, including the bit shifted in on it.
- R4: On an edge where le_i is low, the latches keep their value and out_o does not change, even while the chain keeps shifting.
- R5: data_o always shows the last stage (stage WIDTH), so a bit presented on data_i appears on data_o after exactly WIDTH rising edges.
- R6: While oe_i is low, every bit of out_o is 0 whatever the latches hold. While oe_i is high, each bit follows its latch. oe_i acts combinationally.
- R7: With MAP = MAP_FWD, out_o[k] is driven by the latch of stage k+1, so out_o[0] follows stage 1.
- R8: With MAP = MAP_REV, out_o[WIDTH-1-k] is driven by the latch of stage k+1, so out_o[WIDTH-1] follows stage 1.
- R9: le_i and oe_i have no effect on shifting. The sequence on data_o depends only on data_i and the clock edges.
- R10: With data_o of one instance connected to data_i of a second, the first WIDTH bits shifted in sit in the second instance after 2*WIDTH edges. The first bit is in its last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; the chain advances on each rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Serial data into stage 1 |
| le_i | input | 1 | Latch enable; high makes the latches follow the chain |
| oe_i | input | 1 | Output enable; low forces all parallel outputs to 0 |
| data_o | output | 1 | Serial cascade output, the last stage |
| out_o | output | WIDTH | Gated parallel outputs |

## Verification
The bench pulses latch-enable for a single edge. This shows whether the bit shifted in on that same edge is captured. A design that samples the chain before the shift would show the word one position behind. It shifts a full word with latch-enable low and checks that out_o stays frozen while data_o keeps moving. A design that lets the controls gate the chain would stall the cascade output. Forward and reversed instances take the same stream, so a swapped mapping shows up as a bit-reversed word. A two-device cascade run of 2*WIDTH edges catches an off-by-one in the last-stage tap.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic {
    MAP_FWD = 1'b0,
    MAP_REV = 1'b1
  } map_e;
endpackage

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  output logic [WIDTH-1:0] stage_q_o,
  output logic [WIDTH-1:0] stage_d_o
);
  logic [WIDTH-1:0] stage_q;

  // next-state exposed so the latch bank can see the same-edge shift
  always_comb begin
    stage_d_o = {stage_q[WIDTH-2:0], data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d_o;
  end

  assign stage_q_o = stage_q;

  // R2: stage 1 holds the previous serial input
  a_r2_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q[0] == $past(data_i));
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (le_i) q <= d_i;
  end

  assign q_o = q;

  // R4: closed latches hold
  a_r4_hold_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(le_i) |-> $stable(q));
endmodule

// File: rtl/sld_out_map.sv
module sld_out_map
  import sld_pkg::*;
#(
  parameter int   WIDTH = 32,
  parameter map_e MAP   = MAP_FWD
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] mapped;

  for (genvar k = 0; k < WIDTH; k++) begin : g_map
    if (MAP == MAP_REV) begin : g_rev
      assign mapped[WIDTH-1-k] = latch_i[k];
    end else begin : g_fwd
      assign mapped[k] = latch_i[k];
    end
  end

  assign out_o = oe_i ? mapped : '0;

  // R6: the pin count of ones never exceeds what the latches hold
  always_comb begin
    a_r6_count: assert ($countones(out_o) <= $countones(latch_i));
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int   WIDTH = 32,
  parameter map_e MAP   = MAP_FWD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             le_i,
  input  logic             oe_i,
  output logic             data_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic [WIDTH-1:0] latch_q;

  sld_shift_reg #(.WIDTH(WIDTH)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .stage_q_o (stage_q),
    .stage_d_o (stage_d)
  );

  sld_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .d_i    (stage_d),
    .q_o    (latch_q)
  );

  sld_out_map #(.WIDTH(WIDTH), .MAP(MAP)) u_map (
    .latch_i (latch_q),
    .oe_i    (oe_i),
    .out_o   (out_o)
  );

  assign data_o = stage_q[WIDTH-1];

  // R3: after an open edge the latches match the chain
  a_r3_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(le_i) |-> latch_q == stage_q);

  // R5: cascade output is the previous second-to-last stage
  a_r5_cascade_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o == $past(stage_q[WIDTH-2]));

  // R6: disabled outputs are low
  a_r6_oe_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> out_o == '0);

  // R9: shifting proceeds with latches closed
  a_r9_shift_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(le_i) |-> stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0]));
endmodule

// File: tb/serial_latch_driver_tb_top.sv
module serial_latch_driver_tb_top;
  import sld_pkg::*;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0, le_i = 1'b0, oe_i = 1'b0;
  logic data_o, rev_data_o, far_data_o;
  logic [W-1:0] out_o, rev_out_o, far_out_o;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] m_sr = '0, m_lat = '0, m_far = '0, m_far_lat = '0;

  always #4 clk = ~clk;

  serial_latch_driver #(.WIDTH(W), .MAP(MAP_FWD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .le_i(le_i), .oe_i(oe_i),
    .data_o(data_o), .out_o(out_o));

  serial_latch_driver #(.WIDTH(W), .MAP(MAP_REV)) dut_rev_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .le_i(le_i), .oe_i(oe_i),
    .data_o(rev_data_o), .out_o(rev_out_o));

  serial_latch_driver #(.WIDTH(W), .MAP(MAP_FWD)) dut_far_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_o), .le_i(le_i), .oe_i(oe_i),
    .data_o(far_data_o), .out_o(far_out_o));

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    for (int k = 0; k < W; k++) rev[W-1-k] = v[k];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; drives, clocks, updates model, returns at next negedge
  task automatic step(input logic d, input logic le);
    logic [W-1:0] sr_old;
    data_i = d; le_i = le;
    @(posedge clk);
    sr_old = m_sr;
    m_sr   = {m_sr[W-2:0], d};
    m_far  = {m_far[W-2:0], sr_old[W-1]};
    if (le) begin m_lat = m_sr; m_far_lat = m_far; end
    @(negedge clk);
  endtask

  task automatic chk_outs(input string req);
    chk({req, " fwd R7"}, out_o, oe_i ? m_lat : '0);
    chk({req, " rev R8"}, rev_out_o, oe_i ? rev(m_lat) : '0);
    chk({req, " cascade R5"}, {31'd0, data_o}, {31'd0, m_sr[W-1]});
  endtask

  task automatic t_reset;
    oe_i = 1'b1;
    #1;
    chk("R1 reset out", out_o, '0);
    chk("R1 reset data_o", {31'd0, data_o}, '0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_pattern(input logic [W-1:0] pat);
    for (int i = 0; i < W; i++) step(pat[i], 1'b1);
    chk_outs("R2/R3 pattern");
    chk("R2 word", out_o, rev(pat));
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    held = out_o;
    for (int i = 0; i < W; i++) step(i[0] ^ i[2], 1'b0);
    chk("R4 hold", out_o, held);
    chk_outs("R4/R9 closed shift");
  endtask

  task automatic t_same_edge;
    step(1'b1, 1'b1);
    chk("R3 same-edge bit", {31'd0, out_o[0]}, 32'd1);
    chk_outs("R3 pulse");
    step(1'b0, 1'b0);
    chk_outs("R3 after pulse");
  endtask

  task automatic t_oe;
    oe_i = 1'b0; #1;
    chk("R6 oe low fwd", out_o, '0);
    chk("R6 oe low rev", rev_out_o, '0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
    chk_outs("R6/R9 oe low shifting");
    oe_i = 1'b1; #1;
    chk("R6 oe high", out_o, m_lat);
    @(negedge clk);
  endtask

  task automatic t_cascade(input logic [2*W-1:0] pat);
    for (int i = 0; i < 2*W; i++) step(pat[i], 1'b1);
    chk("R10 far model", m_far_lat, rev(pat[W-1:0]));
    chk("R10 far word", far_out_o, rev(pat[W-1:0]));
    chk("R10 far tail", {31'd0, far_data_o}, {31'd0, pat[0]});
    chk_outs("R10 near");
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_pattern(32'hA5C3_0F81);
    t_pattern(32'h0000_0001);
    t_hold();
    t_same_edge();
    t_oe();
    t_cascade(64'h1357_9BDF_8421_C0DE);
    t_cascade(64'hFFFF_0000_8000_0001);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule